// File: doc/BRIEF.md
# Serial Display Command Stream Monitor

This block listens, without driving anything, to a four-wire serial display link: an active-low select, a serial clock, a data line and a line that marks each byte as an opcode or as a parameter. It oversamples all four wires with its own clock. It rebuilds the bytes most significant bit first and groups them into transactions. A transaction is one opcode followed by the parameter bytes sent after it.

A transaction is reported only when the next opcode byte arrives, because only then is its parameter list known to be complete. The report carries the opcode, whether the opcode is one the monitor recognises, how many parameters were kept, and whether extra parameters were thrown away. It is held on a valid/ready output. The parameter bytes of the report being shown are read through an indexed read port, so a debug agent or a checker can walk them at its own pace.

Top module: `dspi_cmd_monitor`

## Requirements
- R1: While the select line is high, clock and data activity is ignored and any partly received byte is discarded. The first byte after the select falls is received from its first bit.
- R2: A data bit is taken on a rising serial clock edge and shifted in on the falling edge that follows. A falling edge that has no bit taken before it, within the current selection, shifts nothing.
- R3: Bytes are built most significant bit first, and a byte is complete after exactly 8 shifted bits.
- R4: When a byte completes, a low level on the byte-type line marks it as an opcode and a high level marks it as a parameter.
- R5: Each opcode byte after the first closes the transaction in progress and presents it on the output with txn_valid high. txn_valid stays high until a cycle in which txn_ready is high.
- R6: At most 128 parameter bytes are kept per opcode. Further parameters are dropped, txn_count stays at 128, and txn_trunc is set for that transaction.
- R7: txn_known is 1 exactly for the opcodes 0x00, 0x01, 0x04, 0x09, 0x10 to 0x13, 0x20, 0x21, 0x28 to 0x2C, 0x2E, 0x30, 0x36, 0x3A, 0xB1 to 0xB4, 0xB6, 0xC0 to 0xC5, 0xDA to 0xDD, 0xE0, 0xE1 and 0xFC.
- R8: Parameter bytes that arrive before any opcode since reset belong to no transaction and are never reported. The first opcode after reset produces no report.
- R9: If a transaction is still unaccepted when the next one closes, the new one replaces it and ovf_sticky is set until reset.
- R10: prm_data returns the parameter at position prm_idx (0 = first) of the transaction on the output. It is unaffected by parameters of the transaction that is still being received.
- R11: After reset, txn_valid and ovf_sticky are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_cs_n | input | 1 | Link select, active low (asynchronous) |
| ser_sck | input | 1 | Link serial clock (asynchronous) |
| ser_sdi | input | 1 | Link serial data (asynchronous) |
| ser_dc | input | 1 | Byte type: 0 opcode, 1 parameter (asynchronous) |
| txn_valid | output | 1 | A closed transaction is on the output |
| txn_ready | input | 1 | Consumer accepts the shown transaction |
| txn_opcode | output | 8 | Opcode of the shown transaction |
| txn_known | output | 1 | Opcode is in the recognised set |
| txn_count | output | 8 | Number of parameters kept (0 to 128) |
| txn_trunc | output | 1 | Parameters beyond the cap were dropped |
| ovf_sticky | output | 1 | An unaccepted transaction was replaced |
| prm_idx | input | 7 | Parameter index to read |
| prm_data | output | 8 | Parameter byte at prm_idx |

## Verification
A bit counter that slips, or a partial byte that survives a select abort, shifts every later byte. It first shows as a wrong txn_opcode at the next report, about one byte time after the fault. A parameter counter or bank pointer that goes wrong shows as a wrong txn_count or as prm_data bytes from the wrong transaction at that same report. A handshake or overflow fault shows within a cycle of txn_ready, or at the second unaccepted close, as txn_valid or ovf_sticky at the wrong level.

// File: rtl/dspi_mon_pkg.sv
package dspi_mon_pkg;

  // Recognised display opcode set
  function automatic logic opcode_known(input logic [7:0] op);
    case (op)
      8'h00, 8'h01, 8'h04, 8'h09,
      8'h10, 8'h11, 8'h12, 8'h13,
      8'h20, 8'h21, 8'h28, 8'h29, 8'h2A, 8'h2B, 8'h2C, 8'h2E,
      8'h30, 8'h36, 8'h3A,
      8'hB1, 8'hB2, 8'hB3, 8'hB4, 8'hB6,
      8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5,
      8'hDA, 8'hDB, 8'hDC, 8'hDD,
      8'hE0, 8'hE1, 8'hFC:   opcode_known = 1'b1;
      default:               opcode_known = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dspi_sync.sv
module dspi_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[s] <= RST_VAL;
          else        pipe_q[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe_q[s] <= RST_VAL;
          else        pipe_q[s] <= pipe_q[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/dspi_deser.sv
module dspi_deser #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          sdi,
  input  logic          dc,
  output logic          byte_stb,
  output logic [DW-1:0] byte_data,
  output logic          byte_prm
);
  localparam int BCW = $clog2(DW);

  logic          sck_q, sck_n;
  logic          bit_q, bit_n;
  logic          have_q, have_n;
  logic [BCW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] sh_q, sh_n;
  logic          stb_q, stb_n;
  logic [DW-1:0] data_q, data_n;
  logic          prm_q, prm_n;
  logic          rise, fall;
  logic [DW-1:0] shifted;

  assign rise    = sck & ~sck_q;
  assign fall    = ~sck & sck_q;
  assign shifted = {sh_q[DW-2:0], bit_q};

  always_comb begin
    sck_n  = sck;
    bit_n  = bit_q;
    have_n = have_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    stb_n  = 1'b0;
    data_n = data_q;
    prm_n  = prm_q;
    if (cs_n) begin
      cnt_n  = '0;
      sh_n   = '0;
      have_n = 1'b0;
    end else if (rise) begin
      bit_n  = sdi;
      have_n = 1'b1;
    end else if (fall && have_q) begin
      have_n = 1'b0;
      if (cnt_q == BCW'(DW-1)) begin
        cnt_n  = '0;
        sh_n   = '0;
        stb_n  = 1'b1;
        data_n = shifted;
        prm_n  = dc;
      end else begin
        cnt_n  = cnt_q + 1'b1;
        sh_n   = shifted;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      bit_q  <= 1'b0;
      have_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      stb_q  <= 1'b0;
      data_q <= '0;
      prm_q  <= 1'b0;
    end else begin
      sck_q  <= sck_n;
      bit_q  <= bit_n;
      have_q <= have_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      stb_q  <= stb_n;
      data_q <= data_n;
      prm_q  <= prm_n;
    end
  end

  assign byte_stb  = stb_q;
  assign byte_data = data_q;
  assign byte_prm  = prm_q;

  // R1
  cs_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cnt_q == '0 && !have_q));

  // R3
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q);

  // R2
  shift_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !have_q && !rise) |=> $stable(cnt_q));
endmodule

// File: rtl/dspi_grouper.sv
module dspi_grouper #(
  parameter int DW      = 8,
  parameter int MAX_PRM = 128
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        byte_stb,
  input  logic [DW-1:0]               byte_data,
  input  logic                        byte_prm,
  input  logic                        txn_ready,
  input  logic [$clog2(MAX_PRM)-1:0]  prm_idx,
  output logic                        txn_valid,
  output logic [DW-1:0]               txn_opcode,
  output logic                        txn_known,
  output logic [$clog2(MAX_PRM+1)-1:0] txn_count,
  output logic                        txn_trunc,
  output logic                        ovf_sticky,
  output logic [DW-1:0]               prm_data
);
  import dspi_mon_pkg::*;

  localparam int IDXW = $clog2(MAX_PRM);
  localparam int CNTW = $clog2(MAX_PRM+1);

  logic            have_q, have_n;
  logic            bank_q, bank_n;
  logic [DW-1:0]   op_q, op_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic            trunc_q, trunc_n;
  logic            ov_q, ov_n;
  logic [DW-1:0]   oop_q, oop_n;
  logic            oknown_q, oknown_n;
  logic [CNTW-1:0] ocnt_q, ocnt_n;
  logic            otrunc_q, otrunc_n;
  logic            obank_q, obank_n;
  logic            ovf_q, ovf_n;
  logic            cmd_stb, prm_stb, room, wr_en;

  logic [DW-1:0]   mem [2*MAX_PRM];

  assign cmd_stb = byte_stb & ~byte_prm;
  assign prm_stb = byte_stb & byte_prm & have_q;
  assign room    = cnt_q < CNTW'(MAX_PRM);
  assign wr_en   = prm_stb & room;

  always_comb begin
    have_n   = have_q;
    bank_n   = bank_q;
    op_n     = op_q;
    cnt_n    = cnt_q;
    trunc_n  = trunc_q;
    ov_n     = ov_q;
    oop_n    = oop_q;
    oknown_n = oknown_q;
    ocnt_n   = ocnt_q;
    otrunc_n = otrunc_q;
    obank_n  = obank_q;
    ovf_n    = ovf_q;
    if (ov_q && txn_ready) ov_n = 1'b0;
    if (prm_stb) begin
      if (room) cnt_n   = cnt_q + 1'b1;
      else      trunc_n = 1'b1;
    end
    if (cmd_stb) begin
      if (have_q) begin
        ov_n     = 1'b1;
        oop_n    = op_q;
        oknown_n = opcode_known(op_q);
        ocnt_n   = cnt_q;
        otrunc_n = trunc_q;
        obank_n  = bank_q;
        if (ov_q && !txn_ready) ovf_n = 1'b1;
      end
      have_n  = 1'b1;
      bank_n  = ~bank_q;
      op_n    = byte_data;
      cnt_n   = '0;
      trunc_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q   <= 1'b0;
      bank_q   <= 1'b0;
      op_q     <= '0;
      cnt_q    <= '0;
      trunc_q  <= 1'b0;
      ov_q     <= 1'b0;
      oop_q    <= '0;
      oknown_q <= 1'b0;
      ocnt_q   <= '0;
      otrunc_q <= 1'b0;
      obank_q  <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      have_q   <= have_n;
      bank_q   <= bank_n;
      op_q     <= op_n;
      cnt_q    <= cnt_n;
      trunc_q  <= trunc_n;
      ov_q     <= ov_n;
      oop_q    <= oop_n;
      oknown_q <= oknown_n;
      ocnt_q   <= ocnt_n;
      otrunc_q <= otrunc_n;
      obank_q  <= obank_n;
      ovf_q    <= ovf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[{bank_q, cnt_q[IDXW-1:0]}] <= byte_data;
  end

  assign prm_data   = mem[{obank_q, prm_idx}];
  assign txn_valid  = ov_q;
  assign txn_opcode = oop_q;
  assign txn_known  = oknown_q;
  assign txn_count  = ocnt_q;
  assign txn_trunc  = otrunc_q;
  assign ovf_sticky = ovf_q;

  // R6
  cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(MAX_PRM));

  // R5
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !txn_ready) |=> ov_q);

  // R5
  report_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_q) |-> $past(cmd_stb));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R8
  no_report_before_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !have_q |-> !ov_q);

  // R10
  bank_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (have_q && ov_q) |-> (bank_q != obank_q));
endmodule

// File: rtl/dspi_cmd_monitor.sv
module dspi_cmd_monitor #(
  parameter int DW          = 8,
  parameter int MAX_PRM     = 128,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ser_cs_n,
  input  logic                         ser_sck,
  input  logic                         ser_sdi,
  input  logic                         ser_dc,
  output logic                         txn_valid,
  input  logic                         txn_ready,
  output logic [DW-1:0]                txn_opcode,
  output logic                         txn_known,
  output logic [$clog2(MAX_PRM+1)-1:0] txn_count,
  output logic                         txn_trunc,
  output logic                         ovf_sticky,
  input  logic [$clog2(MAX_PRM)-1:0]   prm_idx,
  output logic [DW-1:0]                prm_data
);
  logic       rst_meta, rst_sync;
  logic [3:0] raw, synced;
  logic       b_stb, b_prm;
  logic [DW-1:0] b_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign raw = {ser_cs_n, ser_sck, ser_sdi, ser_dc};

  dspi_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_sync), .d(raw), .q(synced)
  );

  dspi_deser #(.DW(DW)) u_deser (
    .clk(clk), .rst_n(rst_sync),
    .cs_n(synced[3]), .sck(synced[2]), .sdi(synced[1]), .dc(synced[0]),
    .byte_stb(b_stb), .byte_data(b_data), .byte_prm(b_prm)
  );

  dspi_grouper #(.DW(DW), .MAX_PRM(MAX_PRM)) u_group (
    .clk(clk), .rst_n(rst_sync),
    .byte_stb(b_stb), .byte_data(b_data), .byte_prm(b_prm),
    .txn_ready(txn_ready), .prm_idx(prm_idx),
    .txn_valid(txn_valid), .txn_opcode(txn_opcode), .txn_known(txn_known),
    .txn_count(txn_count), .txn_trunc(txn_trunc), .ovf_sticky(ovf_sticky),
    .prm_data(prm_data)
  );
endmodule

// File: tb/tb_dspi_cmd_monitor.sv
module tb_dspi_cmd_monitor;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, cs_n, sck, sdi, dc, ready;
  logic       valid, known, trunc, ovf;
  logic [7:0] opcode, pdata, count;
  logic [6:0] pidx;

  int nchk = 0, nerr = 0;
  bit done = 0;

  bit       m_have;
  int       m_op, m_cnt, e_op, e_cnt;
  bit       m_trunc, e_trunc;
  int       m_data [128];
  int       e_data [128];

  dspi_cmd_monitor dut (
    .clk(clk), .rst_n(rst_n), .ser_cs_n(cs_n), .ser_sck(sck), .ser_sdi(sdi),
    .ser_dc(dc), .txn_valid(valid), .txn_ready(ready), .txn_opcode(opcode),
    .txn_known(known), .txn_count(count), .txn_trunc(trunc),
    .ovf_sticky(ovf), .prm_idx(pidx), .prm_data(pdata)
  );

  function automatic bit exp_known(int op);
    case (op)
      'h00, 'h01, 'h04, 'h09, 'h10, 'h11, 'h12, 'h13, 'h20, 'h21,
      'h28, 'h29, 'h2A, 'h2B, 'h2C, 'h2E, 'h30, 'h36, 'h3A,
      'hB1, 'hB2, 'hB3, 'hB4, 'hB6, 'hC0, 'hC1, 'hC2, 'hC3, 'hC4, 'hC5,
      'hDA, 'hDB, 'hDC, 'hDD, 'hE0, 'hE1, 'hFC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    sdi = b; wclk(2); sck = 1'b1; wclk(3); sck = 1'b0; wclk(3);
  endtask

  task automatic send_byte(int b, logic isprm);
    dc = isprm;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic do_cmd(int op);
    e_op = m_op; e_cnt = m_cnt; e_trunc = m_trunc;
    for (int i = 0; i < 128; i++) e_data[i] = m_data[i];
    send_byte(op, 1'b0);
    m_have = 1; m_op = op; m_cnt = 0; m_trunc = 0;
  endtask

  task automatic do_prm(int b);
    send_byte(b, 1'b1);
    if (m_have) begin
      if (m_cnt < 128) begin m_data[m_cnt] = b; m_cnt++; end
      else m_trunc = 1;
    end
  endtask

  task automatic check_report(string req);
    wclk(8);
    chk(req, "valid", int'(valid), 1);
    chk(req, "opcode", int'(opcode), e_op);
    chk("R7", "known", int'(known), int'(exp_known(e_op)));
    chk(req, "count", int'(count), e_cnt);
    chk(req, "trunc", int'(trunc), int'(e_trunc));
    for (int i = 0; i < e_cnt; i++) begin
      pidx = 7'(i); #1;
      chk("R10", "param", int'(pdata), e_data[i]);
    end
  endtask

  task automatic accept();
    ready = 1'b1; wclk(1); ready = 1'b0; wclk(1);
    chk("R5", "valid after accept", int'(valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL R5 watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(20240611));
    rst_n = 0; cs_n = 1; sck = 0; sdi = 0; dc = 0; ready = 0; pidx = '0;
    m_have = 0; m_op = 0; m_cnt = 0; m_trunc = 0;
    wclk(5); rst_n = 1; wclk(5);
    // R11 reset state
    chk("R11", "valid", int'(valid), 0);
    chk("R11", "ovf", int'(ovf), 0);

    cs_n = 0; wclk(4);
    // R8 stray parameters then first opcode: nothing reported
    do_prm('h77); do_prm('h12);
    do_cmd('h2A);
    wclk(8);
    chk("R8", "valid after first opcode", int'(valid), 0);

    // R3 R4 R5 known opcode with four parameters
    do_prm('h00); do_prm('h10); do_prm('h80); do_prm('h7F);
    do_cmd('h9C);
    check_report("R5");
    chk("R9", "ovf clear", int'(ovf), 0);
    accept();

    // R7 unknown opcode
    do_prm('hC3);
    do_cmd('h29);
    check_report("R4");
    accept();

    // R1 abort mid-byte, then fresh byte
    dc = 1; send_bit(1); send_bit(1); send_bit(0);
    cs_n = 1; wclk(2);
    for (int i = 0; i < 5; i++) send_bit(1'(i));
    wclk(4); cs_n = 0; wclk(4);
    do_prm('hA5);
    do_cmd('h2C);
    check_report("R1");
    accept();

    // R2 falling edge without a captured bit
    cs_n = 1; wclk(2); sck = 1; wclk(4); cs_n = 0; wclk(4); sck = 0; wclk(4);
    do_prm('h3C);
    do_cmd('h11);
    check_report("R2");
    accept();

    // R6 cap and truncation
    for (int i = 0; i < 130; i++) do_prm((i * 3 + 1) & 'hFF);
    do_cmd('h3A);
    check_report("R6");
    accept();

    // R9 overflow: second close replaces unaccepted report
    do_prm('h55); do_prm('h66);
    do_cmd('h01);
    check_report("R5");
    chk("R9", "ovf before replace", int'(ovf), 0);
    do_prm('h5A);
    do_cmd('h00);
    check_report("R9");
    chk("R9", "ovf set", int'(ovf), 1);
    // R10 later parameters leave shown data untouched
    do_prm('hEE); do_prm('hDD);
    check_report("R10");
    accept();
    chk("R9", "ovf stays", int'(ovf), 1);

    // Random transactions (R3 R4 R5 R7 R10)
    for (int t = 0; t < 25; t++) begin
      int op, n;
      op = (t % 3 == 0) ? 'hB4 : int'($urandom_range(0, 255));
      do_cmd(op);
      check_report("R3");
      accept();
      n = int'($urandom_range(0, 5));
      for (int k = 0; k < n; k++) do_prm(int'($urandom_range(0, 255)));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule